// File: doc/BRIEF.md
# Slave-Port FPGA Configuration Loader

This block loads an SRAM-based FPGA through the target's slave serial configuration port. It owns the chip select, serial clock and data lines, drives an active-low configuration reset, and watches the target's configuration-done pin through a two-flop synchronizer. A single `start` pulse runs the whole sequence with no further control: reset, housekeeping wait, bitstream streaming, done check and trailing padding. Bitstream bytes arrive on a valid/ready byte stream that carries an end marker.

The sequence runs in this order. Chip select and reset are pulled low together. The reset is released while chip select stays low, which puts the target into slave mode. The done pin must then read low. After that the block waits for housekeeping and drops chip select high for a short gap.

Next, every byte is shifted out in SPI mode 0, most significant bit first. When the done pin reads high after the last byte, seven zero bytes follow so that the loaded design starts. Any fault returns the pins to idle and raises a sticky error. A request for partial reconfiguration is refused without moving a pin. All delays are parameters in system clock cycles, and their defaults are derived from the clock frequency.

Top module: `fpga_cfg_loader`

## Requirements
- R1: While idle and after reset, chip select is high, serial clock is low, configuration reset is high (inactive), and busy, done and error are all low.
- R2: A start pulse while idle pulls chip select and configuration reset low in the same cycle. The reset stays low for at least RESET_CYC system clock cycles, and chip select stays low for that whole time.
- R3: The configuration reset is released while chip select is still low. If the synchronized done pin reads high DONE_SETTLE cycles later, error is set, no housekeeping wait and no serial clock follow, and the pins return to idle.
- R4: After a good reset, chip select stays low with reset high for at least HOUSE_CYC cycles. Chip select then goes high for at least one cycle before the first serial clock edge.
- R5: Data goes out in SPI mode 0. The clock idles low, toggles only while chip select is low, and stays high for exactly SCK_HALF cycles per pulse. Data is stable while the clock is high, and each byte is sent most significant bit first.
- R6: If the synchronized done pin reads high after the last bitstream byte, exactly 7 zero bytes (56 clocks) are sent, then done is set and error stays low.
- R7: If the done pin is still low after the last bitstream byte, error is set and no padding clocks are sent.
- R8: A start pulse with partial_req high sets error. Busy stays low and no output pin changes.
- R9: Error stays set until the next accepted start, which clears it. A start pulse while busy is ignored and does not restart the sequence.
- R10: At the end of every sequence, whether it succeeded or failed, chip select returns high, the clock is low, reset is high and busy drops.
- R11: s_ready is high only in the streaming phase when the shifter is free and the byte marked last has not yet been taken. Bytes are sent in the order they were accepted, whatever gaps appear on s_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run a configuration |
| partial_req | input | 1 | Qualifies start as a partial reconfiguration request (refused) |
| s_data | input | 8 | Bitstream byte |
| s_valid | input | 1 | s_data holds a byte |
| s_last | input | 1 | Marks the final bitstream byte |
| s_ready | output | 1 | Block takes the byte on this cycle |
| cfg_cs_n | output | 1 | Target chip select, active low |
| cfg_sck | output | 1 | Target serial clock |
| cfg_mosi | output | 1 | Serial data to the target |
| cfg_rst_n | output | 1 | Target configuration reset, active low |
| cfg_done_in | input | 1 | Target configuration-done pin (asynchronous) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence finished successfully |
| error | output | 1 | Sticky fault flag |

## Verification
The bench plays the target. It rebuilds each byte from the pins on every rising clock edge and compares it with a scoreboard of the bytes pushed by the driver, including the expected zero padding. The done pin is modelled in three ways: it rises once every stream byte has arrived, it is stuck high from the start, or it never rises. These separate the success path from the two abort points, and the measured clock counts show whether padding was sent. A run with gaps on s_valid and a stray start pulse mid-stream tests order preservation and the start lockout. A partial request run, with pin activity watched the whole time, shows that the refusal leaves every line untouched.

// File: rtl/fcl_pkg.sv
`timescale 1ns/1ps
package fcl_pkg;

    localparam int unsigned FCL_BYTE_BITS = 8;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_RESET   = 4'd1,
        ST_RELEASE = 4'd2,
        ST_HOUSE   = 4'd3,
        ST_GAP     = 4'd4,
        ST_STREAM  = 4'd5,
        ST_CHECK   = 4'd6,
        ST_PAD     = 4'd7,
        ST_END     = 4'd8
    } fcl_state_e;

    typedef struct packed {
        logic cs_n;
        logic rst_n;
    } fcl_pins_t;

    // Static pin levels for each sequencer phase
    function automatic fcl_pins_t fcl_pins(fcl_state_e s);
        fcl_pins_t p;
        case (s)
            ST_RESET:   begin p.cs_n = 1'b0; p.rst_n = 1'b0; end
            ST_RELEASE,
            ST_HOUSE,
            ST_STREAM,
            ST_CHECK,
            ST_PAD:     begin p.cs_n = 1'b0; p.rst_n = 1'b1; end
            default:    begin p.cs_n = 1'b1; p.rst_n = 1'b1; end
        endcase
        return p;
    endfunction

    function automatic int unsigned fcl_max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Half-period divider, rounded up so the clock never exceeds the target rate
    function automatic int unsigned fcl_half_div(int unsigned clk_hz, int unsigned sck_hz);
        int unsigned d;
        d = (clk_hz + 2 * sck_hz - 1) / (2 * sck_hz);
        return (d < 1) ? 1 : d;
    endfunction

endpackage

// File: rtl/fcl_sync.sv
`timescale 1ns/1ps
module fcl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_async};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fcl_timer.sv
`timescale 1ns/1ps
module fcl_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (load)          cnt <= load_val;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    AST_TIMER_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        load |=> !zero) else $error("timer did not hold loaded value"); // R2
endmodule

// File: rtl/fcl_spi_tx.sv
`timescale 1ns/1ps
module fcl_spi_tx
    import fcl_pkg::*;
#(
    parameter int unsigned HALF = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [FCL_BYTE_BITS-1:0] data,
    output logic                     sck,
    output logic                     mosi,
    output logic                     idle,
    output logic                     byte_done
);
    localparam int unsigned HW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int unsigned BW = $clog2(FCL_BYTE_BITS);
    localparam logic [HW-1:0] HLAST = HW'(HALF - 1);
    localparam logic [BW-1:0] BLAST = BW'(FCL_BYTE_BITS - 1);

    logic                     active;
    logic [HW-1:0]            hcnt;
    logic [BW-1:0]            bitcnt;
    logic [FCL_BYTE_BITS-1:0] sh;
    logic                     sck_q;
    logic                     fin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            hcnt   <= '0;
            bitcnt <= '0;
            sh     <= '0;
            sck_q  <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (!active) begin
                if (load) begin
                    active <= 1'b1;
                    sh     <= data;
                    hcnt   <= '0;
                    bitcnt <= '0;
                    sck_q  <= 1'b0;
                end
            end else if (hcnt == HLAST) begin
                hcnt <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                end else begin
                    sck_q <= 1'b0;
                    if (bitcnt == BLAST) begin
                        active <= 1'b0;
                        fin_q  <= 1'b1;
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                        sh     <= {sh[FCL_BYTE_BITS-2:0], 1'b0};
                    end
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    assign sck       = sck_q;
    assign mosi      = active ? sh[FCL_BYTE_BITS-1] : 1'b0;
    assign idle      = !active;
    assign byte_done = fin_q;

    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sck_q && $past(sck_q)) |-> $stable(mosi)) else $error("data moved while clock high"); // R5
    AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (load && !active) |=> !idle) else $error("load lost"); // R11
endmodule

// File: rtl/fpga_cfg_loader.sv
`timescale 1ns/1ps
module fpga_cfg_loader
    import fcl_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 125_000_000,
    parameter int unsigned SCK_HZ      = 10_000_000,
    parameter int unsigned SCK_HALF    = fcl_half_div(CLK_HZ, SCK_HZ),
    parameter int unsigned RESET_CYC   = CLK_HZ / 1_000_000,
    parameter int unsigned HOUSE_CYC   = (CLK_HZ / 10_000) * 12,
    parameter int unsigned DONE_SETTLE = 4,
    parameter int unsigned PAD_BYTES   = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       partial_req,
    input  logic [7:0] s_data,
    input  logic       s_valid,
    input  logic       s_last,
    output logic       s_ready,
    output logic       cfg_cs_n,
    output logic       cfg_sck,
    output logic       cfg_mosi,
    output logic       cfg_rst_n,
    input  logic       cfg_done_in,
    output logic       busy,
    output logic       done,
    output logic       error
);
    localparam int unsigned GAP_CYC = 2 * SCK_HALF;
    localparam int unsigned TMAX    = fcl_max3(fcl_max3(RESET_CYC, HOUSE_CYC, GAP_CYC), DONE_SETTLE, 1);
    localparam int unsigned TW      = $clog2(TMAX + 2);
    localparam int unsigned PW      = $clog2(PAD_BYTES + 1);
    localparam logic [PW-1:0] PAD_N = PW'(PAD_BYTES);

    fcl_state_e state, nxt;
    fcl_pins_t  pins;

    logic          done_s;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          tx_load;
    logic [7:0]    tx_data;
    logic          tx_idle;
    logic          tx_done;
    logic          take;
    logic          pad_inc;
    logic          set_err;
    logic          set_done;
    logic          clr_flags;
    logic          last_taken;
    logic [PW-1:0] pad_cnt;
    logic          err_q;
    logic          done_q;

    fcl_sync #(.STAGES(2)) u_done_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (cfg_done_in),
        .q       (done_s)
    );

    fcl_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    fcl_spi_tx #(.HALF(SCK_HALF)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (tx_load),
        .data      (tx_data),
        .sck       (cfg_sck),
        .mosi      (cfg_mosi),
        .idle      (tx_idle),
        .byte_done (tx_done)
    );

    assign s_ready = (state == ST_STREAM) && !last_taken && tx_idle;

    always_comb begin
        nxt       = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        tx_load   = 1'b0;
        tx_data   = '0;
        take      = 1'b0;
        pad_inc   = 1'b0;
        set_err   = 1'b0;
        set_done  = 1'b0;
        clr_flags = 1'b0;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    clr_flags = 1'b1;
                    if (partial_req) begin
                        set_err = 1'b1;
                    end else begin
                        nxt      = ST_RESET;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(RESET_CYC);
                    end
                end
            end
            ST_RESET: begin
                if (tmr_zero) begin
                    nxt      = ST_RELEASE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(DONE_SETTLE);
                end
            end
            ST_RELEASE: begin
                if (tmr_zero) begin
                    if (done_s) begin
                        set_err = 1'b1;
                        nxt     = ST_END;
                    end else begin
                        nxt      = ST_HOUSE;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(HOUSE_CYC);
                    end
                end
            end
            ST_HOUSE: begin
                if (tmr_zero) begin
                    nxt      = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(GAP_CYC);
                end
            end
            ST_GAP: begin
                if (tmr_zero) nxt = ST_STREAM;
            end
            ST_STREAM: begin
                if (s_ready && s_valid) begin
                    tx_load = 1'b1;
                    tx_data = s_data;
                    take    = 1'b1;
                end
                if (last_taken && tx_done) begin
                    nxt      = ST_CHECK;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(DONE_SETTLE);
                end
            end
            ST_CHECK: begin
                if (tmr_zero) begin
                    if (done_s) begin
                        nxt = ST_PAD;
                    end else begin
                        set_err = 1'b1;
                        nxt     = ST_END;
                    end
                end
            end
            ST_PAD: begin
                if (tx_idle && (pad_cnt != PAD_N)) begin
                    tx_load = 1'b1;
                    pad_inc = 1'b1;
                end
                if (tx_done && (pad_cnt == PAD_N)) begin
                    set_done = 1'b1;
                    nxt      = ST_END;
                end
            end
            ST_END: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            last_taken <= 1'b0;
            pad_cnt    <= '0;
            err_q      <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            state <= nxt;
            if (clr_flags) begin
                err_q      <= set_err;
                done_q     <= 1'b0;
                last_taken <= 1'b0;
            end else begin
                if (set_err)  err_q  <= 1'b1;
                if (set_done) done_q <= 1'b1;
                if (take)     last_taken <= s_last;
            end
            if (state == ST_CHECK) pad_cnt <= '0;
            else if (pad_inc)      pad_cnt <= pad_cnt + 1'b1;
        end
    end

    assign pins      = fcl_pins(state);
    assign cfg_cs_n  = pins.cs_n;
    assign cfg_rst_n = pins.rst_n;
    assign busy      = (state != ST_IDLE);
    assign done      = done_q;
    assign error     = err_q;

    AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        cfg_sck |-> !cfg_cs_n) else $error("clock without chip select"); // R5
    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cfg_cs_n && cfg_rst_n && !cfg_sck)) else $error("pins not idle"); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (error && !start) |=> error) else $error("error dropped"); // R9
    AST_PARTIAL_NO_PINS: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && partial_req) |=> (!busy && error && cfg_cs_n && cfg_rst_n)) else $error("partial moved pins"); // R8
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && error)) else $error("done and error together"); // R6
    AST_READY_ONLY_STREAM: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (!cfg_cs_n && cfg_rst_n && !cfg_sck)) else $error("ready outside stream"); // R11
endmodule

// File: tb/fpga_cfg_loader_bench.sv
`timescale 1ns/1ps
module fpga_cfg_loader_bench;
    localparam int HALF  = 2;
    localparam int RCYC  = 8;
    localparam int HCYC  = 40;
    localparam int SETL  = 4;
    localparam int NPAD  = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic partial_req = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic s_valid = 1'b0;
    logic s_last = 1'b0;
    logic s_ready, cfg_cs_n, cfg_sck, cfg_mosi, cfg_rst_n, cfg_done_in;
    logic busy, done, error;

    always #4 clk = ~clk;

    fpga_cfg_loader #(
        .SCK_HALF(HALF), .RESET_CYC(RCYC), .HOUSE_CYC(HCYC),
        .DONE_SETTLE(SETL), .PAD_BYTES(NPAD)
    ) u_fpga_cfg_loader (
        .clk(clk), .rst(rst), .start(start), .partial_req(partial_req),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .cfg_cs_n(cfg_cs_n), .cfg_sck(cfg_sck), .cfg_mosi(cfg_mosi),
        .cfg_rst_n(cfg_rst_n), .cfg_done_in(cfg_done_in),
        .busy(busy), .done(done), .error(error)
    );

    // Scoreboard: written by the driver, read by the monitor
    logic [7:0] stim [0:15];
    int         stim_n = 0;
    logic [7:0] exp_mem [0:31];
    int         exp_n = 0;
    int         done_mode = 0;   // 0 never high, 1 stuck high, 2 high after stream bytes
    logic       clr = 1'b0;

    // Monitor state, owned by the sampler
    int   rx_count, sck_rises, rst_low_cyc, hk_cyc, busy_cyc, hi_run;
    int   mon_checks = 0, mon_fail = 0;
    logic cs_bad, rel_cs_low, rst_rose, gap_seen, pin_moved, period_bad;
    logic prev_sck, prev_rst;
    logic [7:0] rx_sh;
    int   rx_bits;

    assign cfg_done_in = (done_mode == 1) || ((done_mode == 2) && (rx_count >= stim_n));

    always @(negedge clk) begin
        if (clr) begin
            rx_count = 0; sck_rises = 0; rst_low_cyc = 0; hk_cyc = 0; busy_cyc = 0;
            hi_run = 0; cs_bad = 0; rel_cs_low = 0; rst_rose = 0; gap_seen = 0;
            pin_moved = 0; period_bad = 0; prev_sck = cfg_sck; prev_rst = cfg_rst_n;
            rx_sh = 8'h00; rx_bits = 0;
        end else begin
            if (busy) busy_cyc++;
            if (!cfg_cs_n || !cfg_rst_n || cfg_sck) pin_moved = 1;
            if (!cfg_rst_n) begin
                rst_low_cyc++;
                if (cfg_cs_n) cs_bad = 1;
            end
            if (!prev_rst && cfg_rst_n) begin
                rst_rose = 1;
                if (!cfg_cs_n) rel_cs_low = 1;
            end
            if (rst_rose && cfg_rst_n && !cfg_cs_n && sck_rises == 0 && !gap_seen) hk_cyc++;
            if (rst_rose && busy && cfg_cs_n && sck_rises == 0) gap_seen = 1;
            if (cfg_sck) hi_run++;
            else if (prev_sck) begin
                if (hi_run != HALF) period_bad = 1;
                hi_run = 0;
            end
            if (!prev_sck && cfg_sck && !cfg_cs_n) begin
                sck_rises++;
                rx_sh = {rx_sh[6:0], cfg_mosi};
                rx_bits++;
                if (rx_bits == 8) begin
                    rx_bits = 0;
                    mon_checks++;
                    if (rx_count >= exp_n) begin
                        mon_fail++;
                        $display("FAIL R6 unexpected byte %0d: got %02h expected none", rx_count, rx_sh);
                    end else if (rx_sh !== exp_mem[rx_count]) begin
                        mon_fail++;
                        $display("FAIL R11 byte %0d: got %02h expected %02h", rx_count, rx_sh, exp_mem[rx_count]);
                    end
                    rx_count++;
                end
            end
            prev_sck = cfg_sck;
            prev_rst = cfg_rst_n;
        end
    end

    int n_checks = 0, n_fail = 0;

    task automatic check(input logic ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic set_stim(input int n, input logic [7:0] seed, input logic with_pad);
        for (int i = 0; i < n; i++) begin
            stim[i]    = seed ^ 8'(i * 37 + 1);
            exp_mem[i] = stim[i];
        end
        stim_n = n;
        exp_n  = n;
        if (with_pad) begin
            for (int i = 0; i < NPAD; i++) exp_mem[n + i] = 8'h00;
            exp_n = n + NPAD;
        end
    endtask

    task automatic clear_obs();
        @(posedge clk); clr = 1'b1;
        @(posedge clk); clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_start(input logic part);
        partial_req = part;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        partial_req = 1'b0;
    endtask

    task automatic drive_stream(input logic gaps);
        for (int i = 0; i < stim_n; i++) begin
            int to;
            if (gaps && (i % 2 == 1)) begin
                s_valid = 1'b0;
                repeat (i + 2) @(negedge clk);
            end
            s_data  = stim[i];
            s_last  = (i == stim_n - 1);
            s_valid = 1'b1;
            to = 0;
            while (!s_ready && to < 5000) begin
                @(negedge clk);
                to++;
            end
            @(negedge clk);
            s_valid = 1'b0;
            s_last  = 1'b0;
        end
    endtask

    task automatic wait_idle(input string tag);
        int cnt;
        cnt = 0;
        @(negedge clk);
        while (busy && cnt < 20000) begin
            @(negedge clk);
            cnt++;
        end
        check(!busy, tag, cnt, 0);
    endtask

    task automatic check_idle_pins(input string tag);
        check(cfg_cs_n && cfg_rst_n && !cfg_sck && !busy, tag,
              {cfg_cs_n, cfg_rst_n, cfg_sck, busy}, 4'b1100);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 n_checks + mon_checks + 1, n_fail + mon_fail + 1);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        clear_obs();

        // R1: reset state
        check(cfg_cs_n && cfg_rst_n && !cfg_sck && !busy && !done && !error, "R1 reset state",
              {cfg_cs_n, cfg_rst_n, cfg_sck, busy, done, error}, 6'b110000);

        // Scenario A: normal load of 5 bytes
        done_mode = 2;
        set_stim(5, 8'hA5, 1'b1);
        clear_obs();
        pulse_start(1'b0);
        check(!cfg_cs_n && !cfg_rst_n, "R2 cs and reset low together", {cfg_cs_n, cfg_rst_n}, 0);
        drive_stream(1'b0);
        wait_idle("R10 normal run ends");
        check(rst_low_cyc >= RCYC && rst_low_cyc <= RCYC + 2, "R2 reset width", rst_low_cyc, RCYC);
        check(!cs_bad, "R2 cs low during reset", cs_bad, 0);
        check(rel_cs_low, "R3 reset released with cs low", rel_cs_low, 1);
        check(hk_cyc >= HCYC, "R4 housekeeping length", hk_cyc, HCYC);
        check(gap_seen, "R4 cs high gap before stream", gap_seen, 1);
        check(!period_bad, "R5 clock high width", period_bad, 0);
        check(sck_rises == 8 * (5 + NPAD), "R6 clock count with padding", sck_rises, 8 * (5 + NPAD));
        check(rx_count == exp_n, "R6 bytes received", rx_count, exp_n);
        check(done && !error, "R6 done flag", {done, error}, 2'b10);
        check_idle_pins("R10 pins idle after success");

        // Scenario B: gaps on valid and a stray start while busy
        set_stim(3, 8'h3C, 1'b1);
        clear_obs();
        pulse_start(1'b0);
        fork
            drive_stream(1'b1);
            begin
                repeat (70) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        wait_idle("R10 gapped run ends");
        check(rx_count == 3 + NPAD, "R11 gapped byte order", rx_count, 3 + NPAD);
        check(rst_low_cyc <= RCYC + 2, "R9 start while busy ignored", rst_low_cyc, RCYC);
        check(done && !error, "R9 gapped run succeeds", {done, error}, 2'b10);

        // Scenario C: done stuck high at reset release
        done_mode = 1;
        set_stim(2, 8'h11, 1'b0);
        exp_n = 0;
        clear_obs();
        pulse_start(1'b0);
        wait_idle("R10 early abort ends");
        check(error && !done, "R3 error on done high", {done, error}, 2'b01);
        check(sck_rises == 0, "R3 no clocks after abort", sck_rises, 0);
        check(busy_cyc < RCYC + SETL + 8, "R3 housekeeping skipped", busy_cyc, RCYC + SETL + 8);
        check_idle_pins("R10 pins idle after abort");

        // Scenario D: done never rises after stream; error cleared by start
        done_mode = 0;
        set_stim(4, 8'h80, 1'b0);
        clear_obs();
        pulse_start(1'b0);
        check(!error && busy, "R9 error cleared on start", {busy, error}, 2'b10);
        drive_stream(1'b0);
        wait_idle("R10 late abort ends");
        check(error && !done, "R7 error when done low", {done, error}, 2'b01);
        check(sck_rises == 32, "R7 no padding clocks", sck_rises, 32);
        check(rx_count == 4, "R7 stream bytes sent", rx_count, 4);
        check_idle_pins("R10 pins idle after late abort");

        // Scenario E: partial request refused
        clear_obs();
        pulse_start(1'b1);
        repeat (20) @(negedge clk);
        check(error, "R8 partial sets error", error, 1);
        check(!pin_moved && busy_cyc == 0, "R8 no pin activity", {pin_moved, busy_cyc[0]}, 0);

        // Scenario F: recovery after refusal
        done_mode = 2;
        set_stim(2, 8'hFF, 1'b1);
        clear_obs();
        pulse_start(1'b0);
        drive_stream(1'b0);
        wait_idle("R10 recovery run ends");
        check(done && !error && rx_count == 2 + NPAD, "R6 recovery success", rx_count, 2 + NPAD);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 n_checks + mon_checks, n_fail + mon_fail);
        $finish;
    end
endmodule